// File: doc/BRIEF.md
# Card Controller Status and Interrupt Register Bank

This block is the register front end of a memory-card host controller. It is reached through a simple strobe interface: a write enable, a read enable, a 12-bit byte address and 32-bit data. Decoding uses address bits 11:2, so each register is one 32-bit word. The block holds the power, clock and data-control settings and a 22-bit status word. It also holds one mask per interrupt line, two by default, and it drives one level interrupt for each mask.

The command and data engines report through a 22-bit `sts_in` vector. Bits 10:0 are event pulses. Each one sets a matching sticky status bit, and only reset or a clear write removes it again. Bits 21:11 are FIFO and activity levels, and the status word copies them every cycle. Software reads the status word, clears the events it has handled by writing ones to the clear register, and programs the masks to choose which conditions raise each interrupt line.

The four response words from the command engine can be read through the bank, and software cannot write them. A fixed eight-word identification area sits at the top of the 4 KiB window. Read data is combinational: it follows the address and `rd_en` in the same cycle and is zero when `rd_en` is low.

Top module: `sdc_reg_bank`

## Requirements
- R1: After reset, the power, clock, data-control, mask and status registers all read as zero, and every irq output is low.
- R2: The power register (0x00) and the clock register (0x04) keep only bits 7:0 of a write. The data-control register (0x2C) also keeps only bits 7:0. Each reads back zero-extended.
- R3: Mask register i sits at 0x3C + 4*i (0x3C and 0x40). It keeps bits 21:0 of a write and reads back with bits 31:22 at zero.
- R4: The status word reads at 0x34. A 1 on sts_in bit k, for k in 10:0, sets status bit k at the next clock edge, and the bit stays set. Status bits 21:11 take the value of sts_in bits 21:11 from the previous cycle.
- R5: A write to 0x38 clears status bit k wherever the written bit k is 1, for k in 10:0. Written bits 31:11 have no effect, status bits 21:11 are unaffected, and reading 0x38 returns zero.
- R6: When an event pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R7: irq[i] is high exactly when status AND mask i is non-zero. It follows the registered status and mask with no added delay.
- R8: Reads at 0x14, 0x18, 0x1C and 0x20 return response words 0 to 3, taken from resp_in[32*k+31:32*k] for word k. Writes to these offsets change nothing.
- R9: A read at 0xFE0 + 4*k, for k in 0..7, returns entry k of the sequence 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R10: Reads from unmapped offsets (for example 0x30, 0x44 and 0x80) return zero, and writes to them change no register. rdata is zero whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| sts_in | input | 22 | Event pulses (10:0) and status levels (21:11) from the engines |
| resp_in | input | 128 | Four response words from the command engine |
| irq | output | 2 | Level interrupts, one for each mask |

## Verification
A clear write and an engine event can fall in the same cycle, and they can target the same status bit. The bench provokes this in two ways. A directed step writes the clear register while the same event bit is pulsing, and a long pseudo-random stretch mixes clear writes with sparse event pulses. Each outcome is judged against a reference model that applies the clear before the set. After every edge the model is compared with the status readback and with both interrupt lines.

// File: rtl/sdc_regs_pkg.sv
package sdc_regs_pkg;

  // Byte offsets of the register words
  localparam int OFF_PWR   = 'h000;
  localparam int OFF_CLK   = 'h004;
  localparam int OFF_RESP  = 'h014;
  localparam int OFF_DCTL  = 'h02C;
  localparam int OFF_STS   = 'h034;
  localparam int OFF_CLR   = 'h038;
  localparam int OFF_MASK  = 'h03C;

  localparam int RESP_N    = 4;
  localparam int ID_N      = 8;

  // Identification byte for word k of the top window
  function automatic logic [7:0] id_byte(input logic [2:0] k);
    logic [7:0] b;
    case (k)
      3'd0:    b = 8'h81;
      3'd1:    b = 8'h11;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sdc_status_core.sv
module sdc_status_core #(
  parameter int STS_W = 22,
  parameter int CLR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] sts_in,
  input  logic             clr_en,
  input  logic [CLR_W-1:0] clr_bits,
  output logic [STS_W-1:0] sts_q
);

  localparam int LVL_W = STS_W - CLR_W;

  logic [CLR_W-1:0] evt_d, evt_q;
  logic [LVL_W-1:0] lvl_d, lvl_q;

  // Clear first, then set: an event in the same cycle wins
  always_comb begin
    evt_d = evt_q;
    if (clr_en) evt_d = evt_d & ~clr_bits;
    evt_d = evt_d | sts_in[CLR_W-1:0];
    lvl_d = sts_in[STS_W-1:CLR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      lvl_q <= '0;
    end else begin
      evt_q <= evt_d;
      lvl_q <= lvl_d;
    end
  end

  assign sts_q = {lvl_q, evt_q};

endmodule

// File: rtl/sdc_irq_unit.sv
module sdc_irq_unit #(
  parameter int STS_W   = 22,
  parameter int NUM_IRQ = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IRQ-1:0]       mask_we,
  input  logic [STS_W-1:0]         mask_wdata,
  input  logic [STS_W-1:0]         sts,
  output logic [NUM_IRQ*STS_W-1:0] mask_flat,
  output logic [NUM_IRQ-1:0]       irq
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic [STS_W-1:0] mask_d, mask_q;

    always_comb begin
      mask_d = mask_q;
      if (mask_we[i]) mask_d = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
    end

    assign mask_flat[i*STS_W +: STS_W] = mask_q;
    assign irq[i] = |(sts & mask_q);
  end

endmodule

// File: rtl/sdc_ctl_regs.sv
module sdc_ctl_regs #(
  parameter int CTL_W = 8,
  parameter int NREG  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       we,
  input  logic [CTL_W-1:0]      wdata,
  output logic [NREG*CTL_W-1:0] regs_flat
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CTL_W-1:0] val_d, val_q;

    always_comb begin
      val_d = val_q;
      if (we[r]) val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign regs_flat[r*CTL_W +: CTL_W] = val_q;
  end

endmodule

// File: rtl/sdc_reg_bank.sv
module sdc_reg_bank
  import sdc_regs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int STS_W   = 22,
  parameter int CLR_W   = 11,
  parameter int CTL_W   = 8,
  parameter int NUM_IRQ = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [STS_W-1:0]         sts_in,
  input  logic [RESP_N*DATA_W-1:0] resp_in,
  output logic [NUM_IRQ-1:0]       irq
);

  localparam int WA_W = ADDR_W - 2;
  localparam int NCTL = 3;
  localparam logic [WA_W-1:0] W_PWR  = WA_W'(OFF_PWR  >> 2);
  localparam logic [WA_W-1:0] W_CLK  = WA_W'(OFF_CLK  >> 2);
  localparam logic [WA_W-1:0] W_DCTL = WA_W'(OFF_DCTL >> 2);
  localparam logic [WA_W-1:0] W_STS  = WA_W'(OFF_STS  >> 2);
  localparam logic [WA_W-1:0] W_CLR  = WA_W'(OFF_CLR  >> 2);
  localparam logic [WA_W-1:0] W_MASK = WA_W'(OFF_MASK >> 2);
  localparam logic [WA_W-1:0] W_RESP = WA_W'(OFF_RESP >> 2);

  logic [WA_W-1:0]            wa;
  logic [NCTL-1:0]            ctl_we;
  logic [NCTL*CTL_W-1:0]      ctl_flat;
  logic [NUM_IRQ-1:0]         mask_we;
  logic [NUM_IRQ*STS_W-1:0]   mask_flat;
  logic [STS_W-1:0]           sts_q;
  logic                       clr_en;
  logic                       id_hit;
  logic                       unused_bits;

  assign wa     = addr[ADDR_W-1:2];
  assign id_hit = &addr[ADDR_W-1:5];
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:STS_W]};

  // Write decode: index 0 power, 1 clock, 2 data control
  always_comb begin
    ctl_we    = '0;
    ctl_we[0] = wr_en && (wa == W_PWR);
    ctl_we[1] = wr_en && (wa == W_CLK);
    ctl_we[2] = wr_en && (wa == W_DCTL);
    clr_en    = wr_en && (wa == W_CLR);
    for (int i = 0; i < NUM_IRQ; i++)
      mask_we[i] = wr_en && (wa == W_MASK + WA_W'(i));
  end

  sdc_ctl_regs #(.CTL_W(CTL_W), .NREG(NCTL)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctl_we),
    .wdata     (wdata[CTL_W-1:0]),
    .regs_flat (ctl_flat)
  );

  sdc_status_core #(.STS_W(STS_W), .CLR_W(CLR_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .sts_in   (sts_in),
    .clr_en   (clr_en),
    .clr_bits (wdata[CLR_W-1:0]),
    .sts_q    (sts_q)
  );

  sdc_irq_unit #(.STS_W(STS_W), .NUM_IRQ(NUM_IRQ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (wdata[STS_W-1:0]),
    .sts        (sts_q),
    .mask_flat  (mask_flat),
    .irq        (irq)
  );

  // Read mux; no read side effects
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (id_hit) begin
        rdata = DATA_W'(id_byte(addr[4:2]));
      end else if (wa == W_PWR) begin
        rdata = DATA_W'(ctl_flat[0*CTL_W +: CTL_W]);
      end else if (wa == W_CLK) begin
        rdata = DATA_W'(ctl_flat[1*CTL_W +: CTL_W]);
      end else if (wa == W_DCTL) begin
        rdata = DATA_W'(ctl_flat[2*CTL_W +: CTL_W]);
      end else if (wa == W_STS) begin
        rdata = DATA_W'(sts_q);
      end else begin
        for (int i = 0; i < NUM_IRQ; i++)
          if (wa == W_MASK + WA_W'(i)) rdata = DATA_W'(mask_flat[i*STS_W +: STS_W]);
        for (int k = 0; k < RESP_N; k++)
          if (wa == W_RESP + WA_W'(k)) rdata = resp_in[k*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/sdc_reg_bank_chk.sv
module sdc_reg_bank_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int STS_W   = 22,
  parameter int CLR_W   = 11,
  parameter int NUM_IRQ = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic [STS_W-1:0]   sts_in,
  input logic [STS_W-1:0]   sts_q,
  input logic [NUM_IRQ-1:0] irq
);

  localparam logic [ADDR_W-3:0] CLR_WORD = (ADDR_W-2)'(14);
  localparam logic [ADDR_W-3:0] PWR_WORD = (ADDR_W-2)'(0);

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_irq_low_chk: assert (irq == '0);
  end

  // R2
  power_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[ADDR_W-1:2] == PWR_WORD) |-> (rdata[DATA_W-1:8] == '0));

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_q[STS_W-1:CLR_W] == $past(sts_in[STS_W-1:CLR_W])));

  // R5
  clear_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1:2] == CLR_WORD && wdata[0] && !sts_in[0]) |=> !sts_q[0]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q[CLR_W-1:0] & $past(sts_in[CLR_W-1:0])) == $past(sts_in[CLR_W-1:0])));

  // R7
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (sts_q != '0));

endmodule

bind sdc_reg_bank sdc_reg_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_W(STS_W), .CLR_W(CLR_W), .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .sts_in(sts_in), .sts_q(sts_q), .irq(irq)
);

// File: tb/sim_sdc_reg_bank.sv
module sim_sdc_reg_bank;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, rd_en;
  logic [11:0]  addr;
  logic [31:0]  wdata, rdata;
  logic [21:0]  sts_in;
  logic [127:0] resp_in;
  logic [1:0]   irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_pwr, m_clk, m_dctl, m_sts;
  int m_mask[2];
  int id_tab[8] = '{'h81, 'h11, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};

  always #(CLK_PERIOD/2) clk = ~clk;

  sdc_reg_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sts_in(sts_in), .resp_in(resp_in), .irq(irq)
  );

  function automatic int mread(input int a);
    int w;
    w = (a & 'hFFC);
    if (w >= 'hFE0) return id_tab[(w - 'hFE0) >> 2];
    case (w)
      'h000: return m_pwr;
      'h004: return m_clk;
      'h02C: return m_dctl;
      'h034: return m_sts;
      'h03C: return m_mask[0];
      'h040: return m_mask[1];
      'h014: return int'(resp_in[31:0]);
      'h018: return int'(resp_in[63:32]);
      'h01C: return int'(resp_in[95:64]);
      'h020: return int'(resp_in[127:96]);
      default: return 0;
    endcase
  endfunction

  task automatic mupdate(input bit w, input int a, input int d, input int s);
    int clr;
    clr = 0;
    if (w) begin
      case (a & 'hFFC)
        'h000: m_pwr  = d & 'hFF;
        'h004: m_clk  = d & 'hFF;
        'h02C: m_dctl = d & 'hFF;
        'h03C: m_mask[0] = d & 'h3FFFFF;
        'h040: m_mask[1] = d & 'h3FFFFF;
        'h038: clr = d & 'h7FF;
        default: ;
      endcase
    end
    m_sts = (((m_sts & 'h7FF) & ~clr) | (s & 'h7FF)) | (s & 'h3FF800);
  endtask

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input bit r, input int a, input int d,
                      input int s, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a[11:0]; wdata = d; sts_in = s[21:0];
    #1;
    check(int'(rdata), r ? mread(a) : 0, tag);
    check(int'(irq[0]), int'((m_sts & m_mask[0]) != 0), "R7 irq0");
    check(int'(irq[1]), int'((m_sts & m_mask[1]) != 0), "R7 irq1");
    @(posedge clk);
    mupdate(w, a, d, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int alist[12] = '{'h000, 'h004, 'h02C, 'h034, 'h038, 'h03C, 'h040,
                      'h014, 'h030, 'h044, 'hFE8, 'h080};
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; sts_in = 0;
    resp_in = {32'hDDDD0004, 32'hCCCC0003, 32'hBBBB0002, 32'hAAAA0001};
    m_pwr = 0; m_clk = 0; m_dctl = 0; m_sts = 0; m_mask[0] = 0; m_mask[1] = 0;
    repeat (3) @(posedge clk);
    #1; check(int'(irq), 0, "R1 irq in reset");
    @(negedge clk); rst_n = 1;

    // R1 reset values
    step(0, 1, 'h000, 0, 0, "R1 power");
    step(0, 1, 'h004, 0, 0, "R1 clock");
    step(0, 1, 'h02C, 0, 0, "R1 dctl");
    step(0, 1, 'h034, 0, 0, "R1 status");
    step(0, 1, 'h03C, 0, 0, "R1 mask0");
    step(0, 1, 'h040, 0, 0, "R1 mask1");

    // R2 width of control registers
    step(1, 0, 'h000, 'hABCD1234, 0, "R2 write");
    step(1, 0, 'h004, 'h0000FF5A, 0, "R2 write");
    step(1, 0, 'h02C, 'h12345687, 0, "R2 write");
    step(0, 1, 'h000, 0, 0, "R2 power");
    step(0, 1, 'h004, 0, 0, "R2 clock");
    step(0, 1, 'h02C, 0, 0, "R2 dctl");

    // R3 masks
    step(1, 0, 'h03C, 'hFFFFFFFF, 0, "R3 write");
    step(0, 1, 'h03C, 0, 0, "R3 mask0");
    step(1, 0, 'h03C, 'h00000001, 0, "R3 write");
    step(1, 0, 'h040, 'h00008000, 0, "R3 write");
    step(0, 1, 'h040, 0, 0, "R3 mask1");

    // R4 sticky events and level bits, R7 interrupts
    step(0, 1, 'h034, 0, 'h000001, "R4 pulse");
    step(0, 1, 'h034, 0, 'h008000, "R4 sticky");
    step(0, 1, 'h034, 0, 'h000000, "R4 level");
    step(0, 1, 'h034, 0, 'h000000, "R4 level gone");

    // R5 clear, upper bits untouched
    step(0, 1, 'h034, 0, 'h3FF800, "R5 prep");
    step(1, 0, 'h038, 'hFFFFFFFF, 'h3FF800, "R5 clear all");
    step(0, 1, 'h034, 0, 'h3FF800, "R5 after clear");
    step(0, 1, 'h038, 0, 0, "R5 clear reads zero");

    // R6 set and clear in the same cycle
    step(0, 0, 'h000, 0, 'h008, "R6 prep");
    step(1, 0, 'h038, 'h008, 'h008, "R6 collide");
    step(0, 1, 'h034, 0, 0, "R6 set wins");
    step(1, 0, 'h038, 'h7FF, 0, "R6 clean");
    step(0, 1, 'h034, 0, 0, "R6 cleared");

    // R8 responses read-only
    for (int k = 0; k < 4; k++) step(0, 1, 'h014 + 4*k, 0, 0, "R8 resp");
    step(1, 0, 'h014, 'h55555555, 0, "R8 write ignored");
    step(0, 1, 'h014, 0, 0, "R8 resp after write");

    // R9 identification area
    for (int k = 0; k < 8; k++) step(0, 1, 'hFE0 + 4*k, 0, 0, "R9 id");

    // R10 unmapped
    step(1, 0, 'h044, 'hFFFFFFFF, 0, "R10 write");
    step(1, 0, 'h080, 'hFFFFFFFF, 0, "R10 write");
    step(0, 1, 'h044, 0, 0, "R10 read 44");
    step(0, 1, 'h080, 0, 0, "R10 read 80");
    step(0, 1, 'h030, 0, 0, "R10 read 30");
    step(0, 1, 'h03C, 0, 0, "R10 mask0 intact");
    step(0, 1, 'h000, 0, 0, "R10 power intact");
    step(0, 0, 'h000, 0, 0, "R10 rd_en low");

    // R6 mixed traffic
    lfsr = 'h1ACE5;
    for (int n = 0; n < 400; n++) begin
      int a, d, s;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB4BCD35C : 0);
      a = alist[(lfsr >>> 4) % 12 < 0 ? 0 : ((lfsr >> 4) & 'hFFFF) % 12];
      d = lfsr ^ (lfsr << 7);
      s = (lfsr & 'h3FF800) | (((lfsr >> 20) & 7) == 0 ? (1 << ((lfsr >> 8) % 11 & 'hF)) & 'h7FF : 0);
      step(lfsr[1], 1, a, d, s, "R6 mixed");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule